// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a link to a 14-bit converter with a serial output. A one-cycle start request drives the active-low select line low. The block then makes exactly sixteen periods of a serial clock, divided down from the system clock. It shifts in the data line and returns the fourteen result bits together with a one-cycle valid strobe. The serial clock rests high whenever select is high.

Each frame is sixteen bits long: two zero bits come first, then the result, most significant bit first. The converter drives the first zero as soon as select falls, and it moves each later bit out on a falling clock edge. The block can capture on either edge. In falling-edge capture it takes every bit on a falling edge. In rising-edge capture it takes the first zero on the first falling edge and the other fifteen bits on rising edges one to fifteen. An abort input raises select early and throws away the partial frame. After every frame, finished or aborted, select stays high for a fixed quiet time before the next start is accepted.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and right after reset, `cs_n_o` and `sclk_o` are 1, and `busy_o`, `valid_o`, `frame_err_o` and `result_o` are 0.
- R2: A `start` pulse seen while `busy_o` is 0 makes `cs_n_o` go low and `busy_o` go high at the next clock edge. A `start` seen while `busy_o` is 1 has no effect.
- R3: `sclk_o` is 1 whenever `cs_n_o` is 1. In a frame it has exactly 16 falling edges and 16 rising edges. The first falling edge comes HALF_DIV system clocks after `cs_n_o` falls, and every later edge comes HALF_DIV system clocks after the previous one.
- R4: With `capture_rise` = 0 at start, `sdata_i` is captured at each of the 16 falling edges. The bits are, in order, lead bit 1, lead bit 2, then result bits 13 down to 0.
- R5: With `capture_rise` = 1 at start, lead bit 1 is captured at the first falling edge. The next 15 bits are captured at rising edges 1 to 15, with result bit 0 at rising edge 15.
- R6: `cs_n_o` rises HALF_DIV system clocks after the 16th rising edge, which is 33×HALF_DIV clocks after `cs_n_o` fell. `valid_o` is high for exactly that one cycle, and `result_o` holds the new result until the next completed frame.
- R7: `frame_err_o` is 1 in the `valid_o` cycle if either lead bit was 1, and 0 otherwise. It is never high outside a `valid_o` cycle. `result_o` still carries the 14 data bits.
- R8: `abort` high while select is low raises `cs_n_o` and `sclk_o` to 1 at the next edge. No `valid_o` follows, and `result_o` keeps its previous value.
- R9: After `cs_n_o` rises, `busy_o` stays 1 and `cs_n_o` stays 1 for QUIET_CYC system clocks. `start` is ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to read a conversion |
| capture_rise | input | 1 | 1 = capture on rising edges, 0 = on falling edges; sampled at start |
| abort | input | 1 | End the current frame early, discarding it |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| busy_o | output | 1 | Frame or quiet time in progress |
| result_o | output | DATA_W | Last completed conversion result |
| valid_o | output | 1 | One-cycle strobe, new result |
| frame_err_o | output | 1 | A lead bit was not zero (with `valid_o`) |

## Verification
Select falls and busy rises one edge after start. Each serial clock edge comes HALF_DIV edges after the previous one, `valid_o` comes 33×HALF_DIV edges after select fell, and `busy_o` drops QUIET_CYC edges after `valid_o`. The bench drives on one falling clock edge and then counts falling edges until each result appears, comparing the count against these figures. It also timestamps every serial clock transition against a falling-edge cycle counter. The converter model changes its data line on select fall and on serial falling edges, so each capture edge reads the bit the requirements assign to it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_QUIET = 2'd2
  } rd_state_t;
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  assign done = en && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= done ? '0 : cnt + W'(1);
    end
  end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word <= '0;
    end else if (en) begin
      word <= {word[W-2:0], din};
    end
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DATA_W    = 14,
  parameter int LEAD_W    = 2,
  parameter int HALF_DIV  = 2,
  parameter int QUIET_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              capture_rise,
  input  logic              abort,
  input  logic              sdata_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  import adc_rd_pkg::*;

  localparam int FRAME_W = DATA_W + LEAD_W;
  localparam int EDGES   = 2 * FRAME_W;
  localparam int EW      = $clog2(EDGES + 1);

  rd_state_t          st;
  logic [EW-1:0]      e_cnt;
  logic               mode_q;
  logic               tick;
  logic               q_done;
  logic               go;
  logic               stop;
  logic               finish;
  logic               cap_en;
  logic [FRAME_W-1:0] word;

  assign go     = (st == ST_IDLE) && start;
  assign stop   = (st == ST_CONV) && abort;
  assign finish = (st == ST_CONV) && !abort && tick && (e_cnt == EW'(EDGES));

  // Next edge index is e_cnt+1; odd indices are falling edges.
  always_comb begin
    cap_en = 1'b0;
    if ((st == ST_CONV) && !abort && tick && (e_cnt != EW'(EDGES))) begin
      if (mode_q) begin
        cap_en = (e_cnt == '0) || (e_cnt[0] && (e_cnt < EW'(EDGES - 2)));
      end else begin
        cap_en = !e_cnt[0];
      end
    end
  end

  adc_rd_timer #(.LIMIT(HALF_DIV)) u_half (
    .clk  (clk),
    .rst  (rst),
    .clr  (go),
    .en   (st == ST_CONV),
    .done (tick)
  );

  adc_rd_timer #(.LIMIT(QUIET_CYC)) u_quiet (
    .clk  (clk),
    .rst  (rst),
    .clr  (finish || stop),
    .en   (st == ST_QUIET),
    .done (q_done)
  );

  adc_rd_shift #(.W(FRAME_W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .clr  (go),
    .en   (cap_en),
    .din  (sdata_i),
    .word (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      e_cnt       <= '0;
      mode_q      <= 1'b0;
      cs_n_o      <= 1'b1;
      sclk_o      <= 1'b1;
      busy_o      <= 1'b0;
      result_o    <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st     <= ST_CONV;
            e_cnt  <= '0;
            mode_q <= capture_rise;
            cs_n_o <= 1'b0;
            busy_o <= 1'b1;
          end
        end
        ST_CONV: begin
          if (abort) begin
            st     <= ST_QUIET;
            cs_n_o <= 1'b1;
            sclk_o <= 1'b1;
          end else if (tick) begin
            if (e_cnt == EW'(EDGES)) begin
              st          <= ST_QUIET;
              cs_n_o      <= 1'b1;
              result_o    <= word[DATA_W-1:0];
              valid_o     <= 1'b1;
              frame_err_o <= |word[FRAME_W-1:DATA_W];
            end else begin
              e_cnt  <= e_cnt + EW'(1);
              sclk_o <= ~sclk_o;
            end
          end
        end
        ST_QUIET: begin
          if (q_done) begin
            st     <= ST_IDLE;
            busy_o <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic abort,
  input logic cs_n_o,
  input logic sclk_o,
  input logic busy_o,
  input logic valid_o,
  input logic frame_err_o
);
  assert_idle_clk_high_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);

  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $past(!busy_o));

  assert_valid_at_cs_rise_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $rose(cs_n_o));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> valid_o);

  assert_abort_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !cs_n_o && abort) |=> (cs_n_o && sclk_o && !valid_o));

  assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> busy_o);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .abort       (abort),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .busy_o      (busy_o),
  .valid_o     (valid_o),
  .frame_err_o (frame_err_o)
);

// File: tb/adc_rd_ctrl_bench.sv
`timescale 1ns/1ps
module adc_rd_ctrl_bench;
  localparam int DATA_W = 14;
  localparam int HALF   = 2;
  localparam int QUIET  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic capture_rise = 1'b0;
  logic abort = 1'b0;
  logic sdata_i = 1'b0;
  logic cs_n_o, sclk_o, busy_o, valid_o, frame_err_o;
  logic [DATA_W-1:0] result_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int falls = 0;
  int rises = 0;
  int last_edge = 0;
  int bad_half = 0;
  int idle_low = 0;
  logic [15:0] fw = '0;
  int idx = 0;

  always #2 clk = ~clk;

  adc_rd_ctrl #(.DATA_W(DATA_W), .LEAD_W(2), .HALF_DIV(HALF), .QUIET_CYC(QUIET)) u_adc_rd_ctrl (
    .clk(clk), .rst(rst), .start(start), .capture_rise(capture_rise),
    .abort(abort), .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .busy_o(busy_o), .result_o(result_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o)
  );

  // Converter model
  always @(negedge cs_n_o) begin
    idx = 0;
    sdata_i = fw[15];
    falls = 0;
    rises = 0;
    last_edge = cyc;
  end
  always @(negedge sclk_o) begin
    if (!cs_n_o) begin
      idx = idx + 1;
      if (idx < 16) sdata_i = fw[15 - idx];
      falls = falls + 1;
      if (cyc - last_edge != HALF) bad_half = bad_half + 1;
      last_edge = cyc;
    end
  end
  always @(posedge sclk_o) begin
    if (!cs_n_o) begin
      rises = rises + 1;
      if (cyc - last_edge != HALF) bad_half = bad_half + 1;
      last_edge = cyc;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst && cs_n_o && !sclk_o) idle_low <= idle_low + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Runs one full frame; checks timing, result and quiet time.
  task automatic run_frame(input logic [15:0] w, input logic mode,
                           input bit poke_start);
    int n;
    fw = w;
    @(negedge clk);
    capture_rise = mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 cs low after start", cs_n_o, 0);
    check("R2 busy after start", busy_o, 1);
    n = 0;
    while (!valid_o && n < 1000) begin
      @(negedge clk);
      n++;
      if (poke_start && n == 10) start = 1'b1;
      if (poke_start && n == 11) start = 1'b0;
    end
    check(mode ? "R5 result rise mode" : "R4 result fall mode",
          int'(result_o), int'(w[13:0]));
    check("R6 valid delay", n, 33 * HALF);
    check("R3 fall count", falls, 16);
    check("R3 rise count", rises, 16);
    check("R7 frame error", frame_err_o, int'(w[15] | w[14]));
    check("R6 cs high with valid", cs_n_o, 1);
    n = 0;
    while (busy_o && n < 1000) begin
      @(negedge clk);
      n++;
      if (poke_start && n == 1) start = 1'b1;
      if (poke_start && n == 2) start = 1'b0;
      if (busy_o && !cs_n_o) check("R9 cs held high in quiet", cs_n_o, 1);
      if (n == 1) check("R6 valid single cycle", valid_o, 0);
    end
    check("R9 quiet length", n, QUIET);
    @(negedge clk);
    check("R9 start in quiet ignored", cs_n_o, 1);
    check("R6 result held", int'(result_o), int'(w[13:0]));
  endtask

  initial begin
    while (cyc < 200000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected<200000", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs reset", cs_n_o, 1);
    check("R1 sclk reset", sclk_o, 1);
    check("R1 busy reset", busy_o, 0);
    check("R1 valid reset", valid_o, 0);
    check("R1 err reset", frame_err_o, 0);
    check("R1 result reset", int'(result_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cs after reset", cs_n_o, 1);
    check("R1 busy after reset", busy_o, 0);

    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 40; i++) begin
        logic [13:0] d;
        if (i == 0) d = 14'h0000;
        else if (i == 1) d = 14'h3fff;
        else if (i < 16) d = 14'(1 << (i - 2));
        else d = 14'((i * 1237 + 5 + m * 411) % 16384);
        run_frame({2'b00, d}, m[0], (i % 7) == 3);
      end
    end

    // R7 lead bit errors in both modes
    run_frame({2'b10, 14'h1234}, 1'b0, 1'b0);
    run_frame({2'b01, 14'h0abc}, 1'b0, 1'b0);
    run_frame({2'b01, 14'h2222}, 1'b1, 1'b0);
    run_frame({2'b10, 14'h3001}, 1'b1, 1'b0);

    // R8 abort mid frame
    run_frame({2'b00, 14'h15a5}, 1'b0, 1'b0);
    begin
      int n;
      bit seen_valid;
      fw = {2'b00, 14'h0f0f};
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      check("R8 cs high after abort", cs_n_o, 1);
      check("R8 sclk high after abort", sclk_o, 1);
      check("R8 no valid on abort", valid_o, 0);
      seen_valid = 1'b0;
      n = 0;
      while (busy_o && n < 1000) begin
        @(negedge clk);
        n++;
        if (valid_o) seen_valid = 1'b1;
      end
      check("R8 no valid later", int'(seen_valid), 0);
      check("R9 quiet after abort", n, QUIET);
      check("R8 result kept", int'(result_o), 'h15a5);
    end
    run_frame({2'b00, 14'h2b3c}, 1'b1, 1'b0);

    check("R3 idle clock stays high", idle_low, 0);
    check("R3 half period spacing", bad_half, 0);
    finish_run();
  end
endmodule